// File: doc/BRIEF.md
# Banked Indirect Address Generator

This block produces 24-bit memory addresses for operand accesses that go through one of four 16-bit pointer registers. The caller names a pointer, an operand size and a direction. The block forms the address by placing an 8-bit bank value above the chosen pointer. The bank value comes from a bank register tied to that pointer. For the stack pointer, it comes from one of two stack banks chosen by a select flag. The operand is then moved over a byte-wide memory port, one byte per handshake, lowest byte first.

After the last byte, the block can advance the pointer by the operand size. This post-increment wraps inside the 16-bit pointer. An explicit pointer write arriving in the same cycle overrides the increment. A read can also be steered into a 32-bit accumulator. A byte or word load moves the old low half up and places the new value underneath. A long load replaces the whole accumulator.

Register write ports for pointers, banks and the accumulator let the surrounding datapath load state. A pointer read port and the accumulator output expose the results.

Top module: `indirect_agu`

## Requirements
- R1: While reset (`rstN` low) is held, and after it is released, all pointers, banks and the accumulator read zero. After release, `opReady` is 1, `done` is 0 and `memReqValid` is 0.
- R2: Byte k of an access goes to address {bank, pointer + k}. Pointers 0 and 1 use the data bank (bank select code 0). Pointer 2 uses the extra data bank (code 1).
- R3: Pointer 3 uses the system stack bank (code 2) when `stackSel` is 1, and the user stack bank (code 3) when it is 0. `stackSel` is sampled in the cycle the operation is accepted.
- R4: Size code 0 moves 1 byte, code 1 moves 2 bytes, and codes 2 and 3 move 4 bytes. The low 16 address bits wrap modulo 2^16 from byte to byte. The upper 8 bits stay fixed for the whole operation.
- R5: An operation is accepted when `opValid` and `opReady` are both high, and `opReady` is high only while idle. Only one byte request is outstanding at a time. A request holds its address, data and direction until `memReqReady` is seen.
- R6: Multi-byte data is little-endian. On a read, byte k is captured from `memRData` in its handshake cycle into `rdData[8k+7:8k]`, and unused bytes read zero. On a write, byte k of `opWrData` is driven on `memWData` with `memWe` at 1.
- R7: With post-increment on, the pointer becomes its starting value plus the byte count, modulo 2^16. Without it, the pointer is unchanged. Operations never modify a bank register.
- R8: A pointer write to the same pointer in the commit cycle (the cycle before `done`) wins over the post-increment.
- R9: A read with `opToAcc` set and size 0 or 1 sets the accumulator to {old low half, zero-extended read value}. A read with size 2 or 3 sets it to the 32-bit read value. Writes and reads without `opToAcc` leave it unchanged.
- R10: `done` is a one-cycle pulse. It is high in the second cycle after the cycle whose handshake carried the last byte, and it coincides with `opReady`. The updated pointer and accumulator are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptrWrEn | input | 1 | Pointer register write enable |
| ptrWrIdx | input | 2 | Pointer register to write |
| ptrWrData | input | 16 | Pointer write value |
| bankWrEn | input | 1 | Bank register write enable |
| bankWrSel | input | 2 | Bank to write: 0 data, 1 extra data, 2 system stack, 3 user stack |
| bankWrData | input | 8 | Bank write value |
| accWrEn | input | 1 | Accumulator write enable |
| accWrData | input | 32 | Accumulator write value |
| stackSel | input | 1 | Stack bank choice for pointer 3 (1 system, 0 user) |
| ptrRdIdx | input | 2 | Pointer register to read |
| ptrRdData | output | 16 | Value of the pointer chosen by ptrRdIdx |
| accOut | output | 32 | Accumulator value |
| opValid | input | 1 | Operation request |
| opReady | output | 1 | Block is idle and accepts an operation |
| opIdx | input | 2 | Pointer used by the operation |
| opSize | input | 2 | Operand size code |
| opPostInc | input | 1 | Advance the pointer after the access |
| opWrite | input | 1 | 1 for a memory write, 0 for a read |
| opToAcc | input | 1 | Load read data into the accumulator |
| opWrData | input | 32 | Write operand, little-endian |
| memReqValid | output | 1 | Byte request valid |
| memReqReady | input | 1 | Memory accepts the byte request |
| memAddr | output | 24 | Byte address |
| memWe | output | 1 | Byte request is a write |
| memWData | output | 8 | Byte write data |
| memRData | input | 8 | Byte read data, valid in the handshake cycle |
| rdData | output | 32 | Assembled read operand |
| done | output | 1 | Operation complete pulse |

## Verification
The bench builds the block with its default 16-bit pointers and 8-bit banks. With these values a single long access from pointer 0xFFFE crosses the wrap point, so the modulo-2^16 byte addressing and the wrapped post-increment are reached directly. The full 24-bit address on the port shows which bank register supplied the upper byte. A memory model with a randomly stalling ready also holds requests across stalls. A second mode keeps ready always high, which fixes the commit cycle so that a competing pointer write can be placed exactly on it.

// File: rtl/agu_pkg.sv
package agu_pkg;

  // Bank register select codes
  localparam logic [1:0] BANK_DATA  = 2'd0;
  localparam logic [1:0] BANK_EXTRA = 2'd1;
  localparam logic [1:0] BANK_SYS   = 2'd2;
  localparam logic [1:0] BANK_USER  = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic latch;   // capture operation and base address
    logic take;    // a byte handshake completes this cycle
    logic commit;  // write back pointer and accumulator
  } agu_strobe_t;

  // Number of bytes moved for a size code
  function automatic logic [2:0] sizeBytes(input logic [1:0] code);
    case (code)
      2'd0:    sizeBytes = 3'd1;
      2'd1:    sizeBytes = 3'd2;
      default: sizeBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int BANK_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      ptrWrEn,
  input  logic [1:0]                ptrWrIdx,
  input  logic [PTR_W-1:0]          ptrWrData,
  input  logic                      bankWrEn,
  input  logic [1:0]                bankWrSel,
  input  logic [BANK_W-1:0]         bankWrData,
  input  logic                      accWrEn,
  input  logic [2*PTR_W-1:0]        accWrData,
  input  logic                      stackSel,
  input  logic [1:0]                ptrRdIdx,
  output logic [PTR_W-1:0]          ptrRdData,
  output logic [2*PTR_W-1:0]        accOut,
  input  logic [1:0]                opIdx,
  input  logic [1:0]                opSize,
  input  logic                      opPostInc,
  input  logic                      opWrite,
  input  logic                      opToAcc,
  input  logic [2*PTR_W-1:0]        opWrData,
  input  agu_strobe_t               strobe,
  input  logic [$clog2(2*PTR_W/8)-1:0] byteIdx,
  output logic [PTR_W+BANK_W-1:0]   memAddr,
  output logic                      memWe,
  output logic [7:0]                memWData,
  input  logic [7:0]                memRData,
  output logic [2*PTR_W-1:0]        rdData
);

  localparam int NUM_PTR  = 4;
  localparam int NUM_BANK = 4;
  localparam int DATA_W   = 2 * PTR_W;

  logic [PTR_W-1:0]  ptrArr [NUM_PTR];
  logic [BANK_W-1:0] bankQ  [NUM_BANK];

  logic [1:0]        idxQ;
  logic [1:0]        sizeQ;
  logic              postIncQ;
  logic              writeQ;
  logic              toAccQ;
  logic [PTR_W-1:0]  basePtrQ;
  logic [BANK_W-1:0] baseBankQ;
  logic [PTR_W-1:0]  stepQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdBufQ;
  logic [DATA_W-1:0] accQ;
  logic [BANK_W-1:0] bankPick;

  // Pointer registers: explicit write has priority over post-increment
  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic [PTR_W-1:0] ptrQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptrQ <= '0;
      end else if (ptrWrEn && (ptrWrIdx == 2'(i))) begin
        ptrQ <= ptrWrData;
      end else if (strobe.commit && postIncQ && (idxQ == 2'(i))) begin
        ptrQ <= basePtrQ + stepQ;
      end
    end
    assign ptrArr[i] = ptrQ;
  end

  // Bank registers: only written through the bank write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANK; b++) bankQ[b] <= '0;
    end else if (bankWrEn) begin
      bankQ[bankWrSel] <= bankWrData;
    end
  end

  // Bank choice follows the pointer index
  always_comb begin
    case (opIdx)
      2'd0, 2'd1: bankPick = bankQ[BANK_DATA];
      2'd2:       bankPick = bankQ[BANK_EXTRA];
      default:    bankPick = stackSel ? bankQ[BANK_SYS] : bankQ[BANK_USER];
    endcase
  end

  // Operation capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ      <= '0;
      sizeQ     <= '0;
      postIncQ  <= 1'b0;
      writeQ    <= 1'b0;
      toAccQ    <= 1'b0;
      basePtrQ  <= '0;
      baseBankQ <= '0;
      stepQ     <= '0;
      wdataQ    <= '0;
    end else if (strobe.latch) begin
      idxQ      <= opIdx;
      sizeQ     <= opSize;
      postIncQ  <= opPostInc;
      writeQ    <= opWrite;
      toAccQ    <= opToAcc;
      basePtrQ  <= ptrArr[opIdx];
      baseBankQ <= bankPick;
      stepQ     <= PTR_W'(sizeBytes(opSize));
      wdataQ    <= opWrData;
    end
  end

  // Read assembly, little-endian
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdBufQ <= '0;
    end else if (strobe.latch) begin
      rdBufQ <= '0;
    end else if (strobe.take && !writeQ) begin
      rdBufQ[{byteIdx, 3'b000} +: 8] <= memRData;
    end
  end

  // Accumulator: short loads shift the old low half up
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (accWrEn) begin
      accQ <= accWrData;
    end else if (strobe.commit && toAccQ && !writeQ) begin
      if (sizeQ[1]) accQ <= rdBufQ;
      else          accQ <= {accQ[PTR_W-1:0], rdBufQ[PTR_W-1:0]};
    end
  end

  assign memAddr   = {baseBankQ, basePtrQ + PTR_W'(byteIdx)};
  assign memWe     = writeQ;
  assign memWData  = wdataQ[{byteIdx, 3'b000} +: 8];
  assign rdData    = rdBufQ;
  assign accOut    = accQ;
  assign ptrRdData = ptrArr[ptrRdIdx];

endmodule

// File: rtl/agu_control.sv
module agu_control
  import agu_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opSize,
  output logic             opReady,
  output logic             memReqValid,
  input  logic             memReqReady,
  output agu_strobe_t      strobe,
  output logic [IDX_W-1:0] byteIdx,
  output logic             done
);

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_COMMIT} agu_state_t;

  agu_state_t       stateQ;
  logic [IDX_W-1:0] cntQ;
  logic [IDX_W-1:0] lastQ;
  logic             doneQ;
  logic [2:0]       nBytes;

  assign nBytes = sizeBytes(opSize);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      lastQ  <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (opValid) begin
            cntQ   <= '0;
            lastQ  <= IDX_W'(nBytes - 3'd1);
            stateQ <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (memReqReady) begin
            if (cntQ == lastQ) stateQ <= ST_COMMIT;
            else               cntQ   <= cntQ + 1'b1;
          end
        end
        ST_COMMIT: begin
          doneQ  <= 1'b1;
          stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign opReady       = (stateQ == ST_IDLE);
  assign memReqValid   = (stateQ == ST_XFER);
  assign strobe.latch  = opReady && opValid;
  assign strobe.take   = memReqValid && memReqReady;
  assign strobe.commit = (stateQ == ST_COMMIT);
  assign byteIdx       = cntQ;
  assign done          = doneQ;

endmodule

// File: rtl/indirect_agu.sv
module indirect_agu
  import agu_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int BANK_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ptrWrEn,
  input  logic [1:0]              ptrWrIdx,
  input  logic [PTR_W-1:0]        ptrWrData,
  input  logic                    bankWrEn,
  input  logic [1:0]              bankWrSel,
  input  logic [BANK_W-1:0]       bankWrData,
  input  logic                    accWrEn,
  input  logic [2*PTR_W-1:0]      accWrData,
  input  logic                    stackSel,
  input  logic [1:0]              ptrRdIdx,
  output logic [PTR_W-1:0]        ptrRdData,
  output logic [2*PTR_W-1:0]      accOut,
  input  logic                    opValid,
  output logic                    opReady,
  input  logic [1:0]              opIdx,
  input  logic [1:0]              opSize,
  input  logic                    opPostInc,
  input  logic                    opWrite,
  input  logic                    opToAcc,
  input  logic [2*PTR_W-1:0]      opWrData,
  output logic                    memReqValid,
  input  logic                    memReqReady,
  output logic [PTR_W+BANK_W-1:0] memAddr,
  output logic                    memWe,
  output logic [7:0]              memWData,
  input  logic [7:0]              memRData,
  output logic [2*PTR_W-1:0]      rdData,
  output logic                    done
);

  localparam int MAX_BYTES = 2 * PTR_W / 8;
  localparam int IDX_W     = $clog2(MAX_BYTES);

  agu_strobe_t      strobe;
  logic [IDX_W-1:0] byteIdx;

  agu_control #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .opValid(opValid), .opSize(opSize), .opReady(opReady),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .strobe(strobe), .byteIdx(byteIdx), .done(done)
  );

  agu_datapath #(.PTR_W(PTR_W), .BANK_W(BANK_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .ptrWrEn(ptrWrEn), .ptrWrIdx(ptrWrIdx), .ptrWrData(ptrWrData),
    .bankWrEn(bankWrEn), .bankWrSel(bankWrSel), .bankWrData(bankWrData),
    .accWrEn(accWrEn), .accWrData(accWrData),
    .stackSel(stackSel), .ptrRdIdx(ptrRdIdx), .ptrRdData(ptrRdData),
    .accOut(accOut),
    .opIdx(opIdx), .opSize(opSize), .opPostInc(opPostInc),
    .opWrite(opWrite), .opToAcc(opToAcc), .opWrData(opWrData),
    .strobe(strobe), .byteIdx(byteIdx),
    .memAddr(memAddr), .memWe(memWe), .memWData(memWData),
    .memRData(memRData), .rdData(rdData)
  );

endmodule

// File: rtl/indirect_agu_chk.sv
module indirect_agu_chk #(
  parameter int PTR_W  = 16,
  parameter int BANK_W = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    accWrEn,
  input logic [2*PTR_W-1:0]      accOut,
  input logic                    opReady,
  input logic                    memReqValid,
  input logic                    memReqReady,
  input logic [PTR_W+BANK_W-1:0] memAddr,
  input logic                    memWe,
  input logic [7:0]              memWData,
  input logic                    done
);

  localparam int AW = PTR_W + BANK_W;

  // R5: a stalled request holds still
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memAddr) && $stable(memWe) && $stable(memWData)));

  // R5: no request while idle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    opReady |-> !memReqValid);

  // R4: next byte of the same operation keeps the bank and steps the low half
  p_byte_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((memReqValid && memReqReady) ##1 memReqValid) |->
      ((memAddr[AW-1:PTR_W] == $past(memAddr[AW-1:PTR_W])) &&
       (memAddr[PTR_W-1:0] == $past(memAddr[PTR_W-1:0]) + 1'b1)));

  // R10: done is a single-cycle pulse seen while idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> opReady);

  // R9: a write transfer never disturbs the accumulator
  p_acc_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memWe && !accWrEn) |=> $stable(accOut));

endmodule

bind indirect_agu indirect_agu_chk #(.PTR_W(PTR_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rstN(rstN), .accWrEn(accWrEn), .accOut(accOut),
  .opReady(opReady), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memAddr(memAddr), .memWe(memWe), .memWData(memWData), .done(done)
);

// File: tb/indirect_agu_test.sv
module indirect_agu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ptrWrEn = 1'b0;
  logic [1:0]  ptrWrIdx = '0;
  logic [15:0] ptrWrData = '0;
  logic        bankWrEn = 1'b0;
  logic [1:0]  bankWrSel = '0;
  logic [7:0]  bankWrData = '0;
  logic        accWrEn = 1'b0;
  logic [31:0] accWrData = '0;
  logic        stackSel = 1'b0;
  logic [1:0]  ptrRdIdx = '0;
  logic [15:0] ptrRdData;
  logic [31:0] accOut;
  logic        opValid = 1'b0;
  logic        opReady;
  logic [1:0]  opIdx = '0;
  logic [1:0]  opSize = '0;
  logic        opPostInc = 1'b0;
  logic        opWrite = 1'b0;
  logic        opToAcc = 1'b0;
  logic [31:0] opWrData = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [23:0] memAddr;
  logic        memWe;
  logic [7:0]  memWData;
  logic [7:0]  memRData = '0;
  logic [31:0] rdData;
  logic        done;

  always #5ns clk = ~clk;

  indirect_agu uut (.*);

  int total = 0;
  int bad = 0;
  int readyMode = 0;

  logic [15:0] mPtr [4];
  logic [7:0]  mBank [4];
  logic [31:0] mAcc;
  logic [7:0]  memOv [logic [23:0]];
  logic [23:0] addrLog [$];
  logic [7:0]  wrLog [$];

  function automatic logic [7:0] patByte(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] memByte(input logic [23:0] a);
    if (memOv.exists(a)) return memOv[a];
    return patByte(a);
  endfunction

  function automatic int nBytesOf(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] bankOf(input logic [1:0] idx, input logic ss);
    if (idx < 2'd2) return mBank[0];
    if (idx == 2'd2) return mBank[1];
    return ss ? mBank[2] : mBank[3];
  endfunction

  // memory model, updated away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      memReqReady = 1'b0;
    end else begin
      memReqReady = (readyMode == 1) ? 1'b1 : (($urandom % 3) != 0);
      memRData = memByte(memAddr);
      if (memReqValid && memReqReady) begin
        addrLog.push_back(memAddr);
        if (memWe) begin
          wrLog.push_back(memWData);
          memOv[memAddr] = memWData;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setPtr(input logic [1:0] idx, input logic [15:0] v);
    @(negedge clk); ptrWrEn = 1'b1; ptrWrIdx = idx; ptrWrData = v;
    @(negedge clk); ptrWrEn = 1'b0;
    mPtr[idx] = v;
  endtask

  task automatic setBank(input logic [1:0] sel, input logic [7:0] v);
    @(negedge clk); bankWrEn = 1'b1; bankWrSel = sel; bankWrData = v;
    @(negedge clk); bankWrEn = 1'b0;
    mBank[sel] = v;
  endtask

  task automatic setAcc(input logic [31:0] v);
    @(negedge clk); accWrEn = 1'b1; accWrData = v;
    @(negedge clk); accWrEn = 1'b0;
    mAcc = v;
  endtask

  task automatic getPtr(input logic [1:0] idx, output logic [15:0] v);
    ptrRdIdx = idx; #1ns; v = ptrRdData;
  endtask

  task automatic runOp(input string tag, input logic [1:0] idx, input logic [1:0] size,
                       input logic post, input logic wr, input logic toAcc, input logic ss,
                       input logic [31:0] wdata, input logic win, input logic [15:0] winVal);
    int n;
    int w;
    int match;
    logic [7:0]  bk;
    logic [15:0] base;
    logic [23:0] ea [4];
    logic [31:0] expRd;
    logic [15:0] pv;
    n = nBytesOf(size);
    bk = bankOf(idx, ss);
    base = mPtr[idx];
    expRd = '0;
    for (int k = 0; k < n; k++) begin
      ea[k] = {bk, 16'(base + 16'(k))};
      if (!wr) expRd[8*k +: 8] = memByte(ea[k]);
    end
    addrLog.delete();
    wrLog.delete();
    @(negedge clk);
    stackSel = ss; opIdx = idx; opSize = size; opPostInc = post;
    opWrite = wr; opToAcc = toAcc; opWrData = wdata; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    stackSel = ~ss;
    if (win) begin
      repeat (n) @(negedge clk);
      ptrWrEn = 1'b1; ptrWrIdx = idx; ptrWrData = winVal;
      @(negedge clk);
      ptrWrEn = 1'b0;
      chk({tag, " R10 done timing"}, 32'(done), 32'd1);
    end
    w = 0;
    while (done !== 1'b1 && w < 100) begin
      @(negedge clk);
      w++;
    end
    if (w >= 100) begin
      total++; bad++;
      $display("FAIL %s R10 no done actual=0 expected=1", tag);
    end
    chk({tag, " R5 ready with done"}, 32'(opReady), 32'd1);
    match = 0;
    for (int k = 0; k < n; k++)
      if (k < addrLog.size() && addrLog[k] === ea[k]) match++;
    if (addrLog.size() != n) match = 99;
    chk({tag, " R2 R3 R4 addresses"}, 32'(match), 32'(n));
    if (wr) begin
      match = 0;
      for (int k = 0; k < n; k++)
        if (k < wrLog.size() && wrLog[k] === wdata[8*k +: 8]) match++;
      chk({tag, " R6 write bytes"}, 32'(match), 32'(n));
    end else begin
      chk({tag, " R6 read data"}, rdData, expRd);
      if (toAcc)
        mAcc = (size[1]) ? expRd : {mAcc[15:0], expRd[15:0]};
    end
    if (win) mPtr[idx] = winVal;
    else if (post) mPtr[idx] = base + 16'(n);
    getPtr(idx, pv);
    chk({tag, " R7 R8 pointer"}, 32'(pv), 32'(mPtr[idx]));
    chk({tag, " R9 accumulator"}, accOut, mAcc);
    @(negedge clk);
    chk({tag, " R10 single pulse"}, 32'(done), 32'd0);
  endtask

  initial begin
    logic [15:0] pv;
    void'($urandom(32'd24681357));
    for (int i = 0; i < 4; i++) begin mPtr[i] = '0; mBank[i] = '0; end
    mAcc = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 acc in reset", accOut, 32'd0);
    chk("R1 no request in reset", 32'(memReqValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready", 32'(opReady), 32'd1);
    chk("R1 done low", 32'(done), 32'd0);
    chk("R1 acc zero", accOut, 32'd0);
    for (int i = 0; i < 4; i++) begin
      getPtr(2'(i), pv);
      chk("R1 pointer zero", 32'(pv), 32'd0);
    end
    // banks zero: stack bank read at address 0
    runOp("R1 zero bank", 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 32'd0, 1'b0, 16'd0);

    // little-endian word load into accumulator
    setBank(2'd0, 8'h78);
    setPtr(2'd1, 16'hD30F);
    setAcc(32'h07162534);
    memOv[24'h78D30F] = 8'hEE;
    memOv[24'h78D310] = 8'hFF;
    runOp("R9 word load", 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0, 1'b0, 16'd0);
    chk("R9 shifted acc", accOut, 32'h2534FFEE);
    chk("R6 word value", rdData, 32'h0000FFEE);
    getPtr(2'd1, pv);
    chk("R7 plain mode keeps pointer", 32'(pv), 32'h0000D30F);

    // bank selection per pointer
    setBank(2'd1, 8'h3A);
    setBank(2'd2, 8'hC1);
    setBank(2'd3, 8'h5E);
    setPtr(2'd0, 16'h0100);
    setPtr(2'd2, 16'h2200);
    setPtr(2'd3, 16'h7FF0);
    runOp("R2 ptr0 data bank", 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 16'd0);
    runOp("R2 ptr2 extra bank", 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'd0, 1'b0, 16'd0);
    runOp("R3 ptr3 system", 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 32'd0, 1'b0, 16'd0);
    runOp("R3 ptr3 user", 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 16'd0);

    // wrap of address and of post-increment, long load into acc
    setPtr(2'd2, 16'hFFFE);
    runOp("R4 wrap long", 2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'd0, 1'b0, 16'd0);
    getPtr(2'd2, pv);
    chk("R7 wrapped pointer", 32'(pv), 32'h00000002);
    runOp("R4 size code 3", 2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 16'd0);

    // writes
    runOp("R6 long write", 2'd3, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 32'hA1B2C3D4, 1'b0, 16'd0);
    runOp("R6 readback", 2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'd0, 1'b0, 16'd0);
    // after the write, pointer 3 advanced by 4; step back to read what was written
    setPtr(2'd3, mPtr[3] - 16'd4);
    runOp("R6 written bytes", 2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'd0, 1'b0, 16'd0);
    chk("R6 written value", rdData, 32'hA1B2C3D4);

    // explicit write in the commit cycle wins
    readyMode = 1;
    setPtr(2'd0, 16'h1000);
    runOp("R8 write wins", 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 16'hABCD);
    getPtr(2'd0, pv);
    chk("R8 pointer value", 32'(pv), 32'h0000ABCD);
    readyMode = 0;

    // constrained random mix
    for (int it = 0; it < 200; it++) begin
      if ((it % 8) == 0) setBank(2'($urandom % 4), 8'($urandom));
      if ((it % 5) == 0) setPtr(2'($urandom % 4), 16'($urandom));
      if ((it % 23) == 0) setAcc($urandom);
      runOp("rand", 2'($urandom % 4), 2'($urandom % 4), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), $urandom, 1'b0, 16'd0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule